// File: doc/BRIEF.md
# LCD Panel Raster and Power-Up Timing Generator

This block produces the raster timing for a parallel RGB LCD panel: a line pulse, a frame pulse, a data-enable strobe and the current horizontal and vertical position. Each axis is described at run time by four sizes: visible span, front porch, sync width and back porch. Horizontal sizes count pixels and vertical sizes count lines. Each output has its own polarity selection. The sync pulses can be launched on the clock edge opposite to pixel data, or on an explicitly chosen rising or falling edge. Passive-matrix operation pins the edge choice to the opposite-edge mode.

A run input controls the panel supply through a two-stage power-up sequence. Raising run turns panel power on at once. The block then waits a supply-ramp delay in milliseconds and starts the raster. It then waits a picture-settling delay in milliseconds and raises a ready flag. The millisecond base comes from a prescaler derived from the `CLK_HZ` parameter. Lowering run shuts everything down immediately. New raster sizes take effect only when a frame begins.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset with run low, panel power and ready are 0, cfg_err_o is 0, and de_o, hsync_o and vsync_o sit at their inactive levels as set by the polarity inputs.
- R2: Within a line, pix_x_o steps by one per clock from 0 to A+F+S+B-1 and then returns to 0. Here A, F, S and B are h_act_i, h_fp_i, h_sw_i and h_bp_i. The raw line pulse is active for exactly the positions A+F to A+F+S-1, so a sync width of 0 gives no pulse.
- R3: pix_y_o advances by one each time pix_x_o wraps, and runs from 0 to the vertical total minus 1. The raw frame pulse is active on lines v_act_i+v_fp_i up to v_act_i+v_fp_i+v_sw_i-1. Both active sizes must be at least 1.
- R4: The raw data enable is active exactly when pix_x_o < h_act_i and pix_y_o < v_act_i, in the same cycle as those positions appear.
- R5: de_o is active high when de_pol_i=1 and active low when de_pol_i=0. hsync_o and vsync_o are active high when their invert input is 0 and active low when it is 1. pclk_o equals clk when pclk_inv_i=0 and equals the inverse of clk when pclk_inv_i=1.
- R6: Pixel data and data enable change on the rising clock edge. With edge_sel_i=0 the sync outputs change on the falling edge. With edge_sel_i=1, edge_fall_i=0 makes them change on the rising edge and edge_fall_i=1 makes them change on the falling edge.
- R7: With passive_i=1, edge_sel_i is treated as 0, so the syncs launch on the falling edge. cfg_err_o is 1 exactly when passive_i=1 and edge_sel_i=1.
- R8: Take the rising edge that first samples run high as edge 0. Panel power is high after edge 0. The first data enable appears after edge P*T+2 and ready appears after edge (P+Q)*T+2. Here P is pup_ms_i, Q is pon_ms_i and T=CLK_HZ/1000.
- R9: A delay of zero milliseconds occupies exactly one clock, so with P=Q=0 both data enable and ready appear after edge 2.
- R10: The sizes are captured only at a frame boundary. A change made mid-frame leaves the rest of that frame untouched and governs the next frame from its first pixel.
- R11: When run goes low, ready and panel power fall in the same cycle. Data enable is inactive after the next rising edge, and both syncs are inactive by the falling edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Start (1) / stop (0) |
| passive_i | input | 1 | Passive-matrix panel mode |
| edge_sel_i | input | 1 | 0: syncs on opposite edge; 1: edge from edge_fall_i |
| edge_fall_i | input | 1 | Explicit sync edge: 0 rising, 1 falling |
| de_pol_i | input | 1 | 1: data enable active high |
| pclk_inv_i | input | 1 | 1: invert pixel clock output |
| hs_inv_i | input | 1 | 1: line pulse active low |
| vs_inv_i | input | 1 | 1: frame pulse active low |
| h_act_i | input | H_W | Visible pixels per line |
| h_fp_i | input | H_W | Horizontal front porch |
| h_sw_i | input | H_W | Line pulse width |
| h_bp_i | input | H_W | Horizontal back porch |
| v_act_i | input | V_W | Visible lines per frame |
| v_fp_i | input | V_W | Vertical front porch |
| v_sw_i | input | V_W | Frame pulse width in lines |
| v_bp_i | input | V_W | Vertical back porch |
| pup_ms_i | input | MS_W | Supply ramp delay, ms |
| pon_ms_i | input | MS_W | Picture settle delay, ms |
| pclk_o | output | 1 | Pixel clock to panel |
| hsync_o | output | 1 | Line pulse |
| vsync_o | output | 1 | Frame pulse |
| de_o | output | 1 | Data enable |
| pix_x_o | output | H_W+2 | Horizontal position |
| pix_y_o | output | V_W+2 | Vertical position |
| panel_pwr_o | output | 1 | Panel supply enable |
| ready_o | output | 1 | Display ready |
| cfg_err_o | output | 1 | Illegal edge setting in passive mode |

## Verification
Two events can land on the same edge: a frame wrap, which reloads the captured sizes, and the bench rewriting the size inputs. The bench rewrites all eight sizes with fresh random values while the second line is being scanned. It then checks every position step and every strobe against the old sizes until the observed position returns to (0,0), and against the new sizes from that cycle on. A mismatch at the seam shows up as a wrong position step or a misplaced pulse in the last line of the old frame or the first line of the new one.

// File: rtl/lcdt_pkg.sv
`timescale 1ns/1ps
package lcdt_pkg;

  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_RAMP  = 2'd1,
    PS_STAB  = 2'd2,
    PS_READY = 2'd3
  } pwr_state_e;

  // Pixel data launches on the rising edge; the default sync edge is the falling one.
  function automatic logic sync_on_fall(input logic passive,
                                        input logic mode,
                                        input logic fall);
    return (mode && !passive) ? fall : 1'b1;
  endfunction

endpackage

// File: rtl/lcdt_ms_delay.sv
`timescale 1ns/1ps
module lcdt_ms_delay #(
  parameter int TICKS_PER_MS = 25000,
  parameter int MS_W         = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            done_o
);
  localparam int PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_MS - 1);

  logic [PW-1:0]   pre_q, pre_d;
  logic [MS_W-1:0] ms_q, ms_d;

  assign done_o = (ms_q >= ms_i);

  always_comb begin
    pre_d = pre_q;
    ms_d  = ms_q;
    if (clr_i) begin
      pre_d = '0;
      ms_d  = '0;
    end else if (!done_o) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        ms_d  = ms_q + MS_W'(1);
      end else begin
        pre_d = pre_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end

  assert_prescale_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PRE_LAST);

endmodule

// File: rtl/lcdt_pwr_seq.sv
`timescale 1ns/1ps
module lcdt_pwr_seq
  import lcdt_pkg::*;
#(
  parameter int CLK_HZ = 25_000_000,
  parameter int MS_W   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [MS_W-1:0] pup_ms_i,
  input  logic [MS_W-1:0] pon_ms_i,
  output logic            pwr_o,
  output logic            tim_en_o,
  output logic            ready_o
);
  localparam int TPM = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;

  pwr_state_e      state_q, state_d;
  logic            dly_done, dly_clr;
  logic [MS_W-1:0] dly_ms;

  assign dly_ms  = (state_q == PS_RAMP) ? pup_ms_i : pon_ms_i;
  assign dly_clr = (state_d != state_q) || (state_q == PS_OFF) || (state_q == PS_READY);

  lcdt_ms_delay #(.TICKS_PER_MS(TPM), .MS_W(MS_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (dly_clr),
    .ms_i   (dly_ms),
    .done_o (dly_done)
  );

  always_comb begin
    state_d = state_q;
    if (!run_i) begin
      state_d = PS_OFF;
    end else begin
      unique case (state_q)
        PS_OFF:   state_d = PS_RAMP;
        PS_RAMP:  if (dly_done) state_d = PS_STAB;
        PS_STAB:  if (dly_done) state_d = PS_READY;
        PS_READY: state_d = PS_READY;
        default:  state_d = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_OFF;
    else        state_q <= state_d;
  end

  assign pwr_o    = run_i && (state_q != PS_OFF);
  assign tim_en_o = run_i && ((state_q == PS_STAB) || (state_q == PS_READY));
  assign ready_o  = run_i && (state_q == PS_READY);

  assert_ready_follows_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_READY) |-> ($past(state_q) == PS_STAB || $past(state_q) == PS_READY));

  assert_zero_ramp_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RAMP && run_i && pup_ms_i == '0) |=> (state_q == PS_STAB));

  assert_stop_returns_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (state_q == PS_OFF));

endmodule

// File: rtl/lcdt_axis.sv
`timescale 1ns/1ps
module lcdt_axis #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] act_i,
  input  logic [W-1:0] fp_i,
  input  logic [W-1:0] sw_i,
  input  logic [W-1:0] bp_i,
  output logic [W+1:0] pos_o,
  output logic         last_o,
  output logic         in_act_o,
  output logic         in_sync_o
);
  localparam int TW = W + 2;

  logic [TW-1:0] pos_q, pos_d;
  logic [TW-1:0] act_q, act_d, beg_q, beg_d, end_q, end_d, tot_q, tot_d;

  // Shadowed sizes, captured only when the top asks (frame boundary or idle).
  always_comb begin
    act_d = act_q;
    beg_d = beg_q;
    end_d = end_q;
    tot_d = tot_q;
    if (load_i) begin
      act_d = TW'(act_i);
      beg_d = TW'(act_i) + TW'(fp_i);
      end_d = TW'(act_i) + TW'(fp_i) + TW'(sw_i);
      tot_d = TW'(act_i) + TW'(fp_i) + TW'(sw_i) + TW'(bp_i);
    end
  end

  assign last_o    = (pos_q == tot_q - TW'(1));
  assign in_act_o  = (pos_q < act_q);
  assign in_sync_o = (pos_q >= beg_q) && (pos_q < end_q);
  assign pos_o     = pos_q;

  always_comb begin
    pos_d = pos_q;
    if (clr_i)       pos_d = '0;
    else if (step_i) pos_d = last_o ? '0 : pos_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      act_q <= '0;
      beg_q <= '0;
      end_q <= '0;
      tot_q <= '0;
    end else begin
      pos_q <= pos_d;
      act_q <= act_d;
      beg_q <= beg_d;
      end_q <= end_d;
      tot_q <= tot_d;
    end
  end

  assert_pos_below_total_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |-> (pos_q < tot_q));

  assert_reload_only_at_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) |-> last_o);

endmodule

// File: rtl/lcd_timing_gen.sv
`timescale 1ns/1ps
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int CLK_HZ = 25_000_000,
  parameter int H_W    = 11,
  parameter int V_W    = 11,
  parameter int MS_W   = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic           passive_i,
  input  logic           edge_sel_i,
  input  logic           edge_fall_i,
  input  logic           de_pol_i,
  input  logic           pclk_inv_i,
  input  logic           hs_inv_i,
  input  logic           vs_inv_i,
  input  logic [H_W-1:0] h_act_i,
  input  logic [H_W-1:0] h_fp_i,
  input  logic [H_W-1:0] h_sw_i,
  input  logic [H_W-1:0] h_bp_i,
  input  logic [V_W-1:0] v_act_i,
  input  logic [V_W-1:0] v_fp_i,
  input  logic [V_W-1:0] v_sw_i,
  input  logic [V_W-1:0] v_bp_i,
  input  logic [MS_W-1:0] pup_ms_i,
  input  logic [MS_W-1:0] pon_ms_i,
  output logic           pclk_o,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic [H_W+1:0] pix_x_o,
  output logic [V_W+1:0] pix_y_o,
  output logic           panel_pwr_o,
  output logic           ready_o,
  output logic           cfg_err_o
);
  localparam int HTW = H_W + 2;
  localparam int VTW = V_W + 2;

  logic           tim_en;
  logic           h_last, h_act, h_sync, v_last, v_act, v_sync;
  logic           axis_clr, axis_load, v_step;
  logic [HTW-1:0] h_pos, x_q, x_d;
  logic [VTW-1:0] v_pos, y_q, y_d;
  logic           de_q, de_d, hs_q, hs_d, vs_q, vs_d;
  logic           hs_n, vs_n;
  logic           fall_sel;

  lcdt_pwr_seq #(.CLK_HZ(CLK_HZ), .MS_W(MS_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_i),
    .pup_ms_i (pup_ms_i),
    .pon_ms_i (pon_ms_i),
    .pwr_o    (panel_pwr_o),
    .tim_en_o (tim_en),
    .ready_o  (ready_o)
  );

  assign axis_clr  = !tim_en;
  assign axis_load = !tim_en || (h_last && v_last);
  assign v_step    = tim_en && h_last;

  lcdt_axis #(.W(H_W)) u_hax (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (axis_clr),
    .step_i    (tim_en),
    .load_i    (axis_load),
    .act_i     (h_act_i),
    .fp_i      (h_fp_i),
    .sw_i      (h_sw_i),
    .bp_i      (h_bp_i),
    .pos_o     (h_pos),
    .last_o    (h_last),
    .in_act_o  (h_act),
    .in_sync_o (h_sync)
  );

  lcdt_axis #(.W(V_W)) u_vax (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (axis_clr),
    .step_i    (v_step),
    .load_i    (axis_load),
    .act_i     (v_act_i),
    .fp_i      (v_fp_i),
    .sw_i      (v_sw_i),
    .bp_i      (v_bp_i),
    .pos_o     (v_pos),
    .last_o    (v_last),
    .in_act_o  (v_act),
    .in_sync_o (v_sync)
  );

  // Rising-edge output stage: position, data enable and raw sync levels.
  always_comb begin
    x_d  = h_pos;
    y_d  = v_pos;
    de_d = tim_en && h_act && v_act;
    hs_d = tim_en && h_sync;
    vs_d = tim_en && v_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= '0;
      y_q  <= '0;
      de_q <= 1'b0;
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      x_q  <= x_d;
      y_q  <= y_d;
      de_q <= de_d;
      hs_q <= hs_d;
      vs_q <= vs_d;
    end
  end

  // Falling-edge copy of the syncs, half a cycle later.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_n <= 1'b0;
      vs_n <= 1'b0;
    end else begin
      hs_n <= hs_q;
      vs_n <= vs_q;
    end
  end

  assign fall_sel  = sync_on_fall(passive_i, edge_sel_i, edge_fall_i);
  assign cfg_err_o = passive_i && edge_sel_i;

  assign hsync_o = (fall_sel ? hs_n : hs_q) ^ hs_inv_i;
  assign vsync_o = (fall_sel ? vs_n : vs_q) ^ vs_inv_i;
  assign de_o    = de_pol_i ? de_q : !de_q;
  assign pclk_o  = clk ^ pclk_inv_i;
  assign pix_x_o = x_q;
  assign pix_y_o = y_q;

  assert_sync_outside_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_q |-> !de_q);

  assert_stop_blanks_outputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!de_q && !hs_q && !vs_q));

endmodule

// File: tb/lcd_timing_gen_tb.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb;
  localparam int CLK_HZ = 8000;
  localparam int TPM    = CLK_HZ / 1000;
  localparam int H_W    = 6;
  localparam int V_W    = 6;
  localparam int MS_W   = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic run_i, passive_i, edge_sel_i, edge_fall_i;
  logic de_pol_i, pclk_inv_i, hs_inv_i, vs_inv_i;
  logic [H_W-1:0] h_act_i, h_fp_i, h_sw_i, h_bp_i;
  logic [V_W-1:0] v_act_i, v_fp_i, v_sw_i, v_bp_i;
  logic [MS_W-1:0] pup_ms_i, pon_ms_i;
  logic pclk_o, hsync_o, vsync_o, de_o, panel_pwr_o, ready_o, cfg_err_o;
  logic [H_W+1:0] pix_x_o;
  logic [V_W+1:0] pix_y_o;

  int checks = 0;
  int errors = 0;
  int cur[8];
  int pend[8];

  always #2 clk = ~clk;

  lcd_timing_gen #(.CLK_HZ(CLK_HZ), .H_W(H_W), .V_W(V_W), .MS_W(MS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .passive_i(passive_i),
    .edge_sel_i(edge_sel_i), .edge_fall_i(edge_fall_i), .de_pol_i(de_pol_i),
    .pclk_inv_i(pclk_inv_i), .hs_inv_i(hs_inv_i), .vs_inv_i(vs_inv_i),
    .h_act_i(h_act_i), .h_fp_i(h_fp_i), .h_sw_i(h_sw_i), .h_bp_i(h_bp_i),
    .v_act_i(v_act_i), .v_fp_i(v_fp_i), .v_sw_i(v_sw_i), .v_bp_i(v_bp_i),
    .pup_ms_i(pup_ms_i), .pon_ms_i(pon_ms_i), .pclk_o(pclk_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_x_o(pix_x_o),
    .pix_y_o(pix_y_o), .panel_pwr_o(panel_pwr_o), .ready_o(ready_o),
    .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int htot(input int c[8]);
    return c[0] + c[1] + c[2] + c[3];
  endfunction

  function automatic int vtot(input int c[8]);
    return c[4] + c[5] + c[6] + c[7];
  endfunction

  function automatic bit in_win(input int p, input int beg, input int w);
    return (p >= beg) && (p < beg + w);
  endfunction

  task automatic drive_cfg(input int c[8]);
    h_act_i = H_W'(c[0]); h_fp_i = H_W'(c[1]); h_sw_i = H_W'(c[2]); h_bp_i = H_W'(c[3]);
    v_act_i = V_W'(c[4]); v_fp_i = V_W'(c[5]); v_sw_i = V_W'(c[6]); v_bp_i = V_W'(c[7]);
  endtask

  task automatic rand_cfg(output int c[8]);
    c[0] = $urandom_range(2, 8); c[1] = $urandom_range(0, 3);
    c[2] = $urandom_range(0, 3); c[3] = $urandom_range(0, 3);
    c[4] = $urandom_range(1, 4); c[5] = $urandom_range(0, 2);
    c[6] = $urandom_range(0, 2); c[7] = $urandom_range(0, 2);
  endtask

  task automatic stop_run();
    @(negedge clk); #1;
    run_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
  endtask

  // R6 / R7: find the phase in which the line pulse first becomes active.
  task automatic edge_probe(input bit sel, input bit fall, input bit pas,
                            input bit exp_fall, input string req);
    bit seen = 0;
    bit seen_fall = 0;
    int d[8];
    stop_run();
    d[0] = 4; d[1] = 1; d[2] = 2; d[3] = 1; d[4] = 2; d[5] = 1; d[6] = 1; d[7] = 1;
    drive_cfg(d);
    hs_inv_i = 0; vs_inv_i = 0; pup_ms_i = 0; pon_ms_i = 0;
    edge_sel_i = sel; edge_fall_i = fall; passive_i = pas;
    #0.5;
    chk(cfg_err_o == (pas && sel), "R7", "cfg_err_o", int'(cfg_err_o), int'(pas && sel));
    run_i = 1'b1;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(posedge clk); #1;
      if (hsync_o) begin seen = 1; seen_fall = 0; end
      if (!seen) begin
        @(negedge clk); #1;
        if (hsync_o) begin seen = 1; seen_fall = 1; end
      end
    end
    chk(seen, req, "line pulse seen", int'(seen), 1);
    chk(seen_fall == exp_fall, req, "sync launch on falling edge",
        int'(seen_fall), int'(exp_fall));
  endtask

  // R8 / R9: edge counts from run sampled high to power, first DE and ready.
  task automatic pwr_probe(input int pup, input int pon);
    int f_pwr = -1;
    int f_de  = -1;
    int f_rdy = -1;
    int d[8];
    string req;
    req = (pup == 0 && pon == 0) ? "R9" : "R8";
    stop_run();
    d[0] = 3; d[1] = 1; d[2] = 1; d[3] = 1; d[4] = 2; d[5] = 1; d[6] = 1; d[7] = 1;
    drive_cfg(d);
    de_pol_i = 1; pup_ms_i = MS_W'(pup); pon_ms_i = MS_W'(pon);
    chk(panel_pwr_o == 0, req, "power before run", int'(panel_pwr_o), 0);
    run_i = 1'b1;
    for (int i = 0; i < (pup + pon) * TPM + 8; i++) begin
      @(posedge clk); #1;
      if (panel_pwr_o && f_pwr < 0) f_pwr = i;
      if (de_o && f_de < 0) f_de = i;
      if (ready_o && f_rdy < 0) f_rdy = i;
    end
    chk(f_pwr == 0, req, "power edge index", f_pwr, 0);
    chk(f_de == pup * TPM + 2, req, "first data enable edge index", f_de, pup * TPM + 2);
    chk(f_rdy == (pup + pon) * TPM + 2, req, "ready edge index", f_rdy, (pup + pon) * TPM + 2);
  endtask

  // R2 R3 R4 R5 R10: random raster checked sample by sample.
  task automatic raster(input int nsamp, input bit change);
    int px = 0;
    int py = 0;
    bit have = 0;
    bit chg_done = 0;
    bit chg_live = 0;
    stop_run();
    rand_cfg(cur);
    pend = cur;
    drive_cfg(cur);
    de_pol_i = 1'($urandom_range(0, 1)); hs_inv_i = 1'($urandom_range(0, 1));
    vs_inv_i = 1'($urandom_range(0, 1)); pclk_inv_i = 1'($urandom_range(0, 1));
    edge_sel_i = 1'($urandom_range(0, 1)); edge_fall_i = 1'($urandom_range(0, 1));
    passive_i = 1'($urandom_range(0, 1));
    pup_ms_i = 0; pon_ms_i = 0;
    run_i = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk(pclk_o == !pclk_inv_i, "R5", "pclk_o while clk high", int'(pclk_o), int'(!pclk_inv_i));
    for (int i = 0; i < nsamp; i++) begin
      int x, y, ex, ey, ht, vt;
      bit e_de, e_hs, e_vs;
      @(negedge clk); #1;
      x = int'(pix_x_o);
      y = int'(pix_y_o);
      if (i == 0)
        chk(pclk_o == pclk_inv_i, "R5", "pclk_o while clk low", int'(pclk_o), int'(pclk_inv_i));
      if (have) begin
        ht = htot(cur); vt = vtot(cur);
        ex = (px == ht - 1) ? 0 : px + 1;
        ey = (px == ht - 1) ? ((py == vt - 1) ? 0 : py + 1) : py;
        chk(x == ex, chg_live ? "R10" : "R2", "pix_x step", x, ex);
        chk(y == ey, chg_live ? "R10" : "R3", "pix_y step", y, ey);
      end
      if (x == 0 && y == 0) begin
        cur = pend;
        chg_live = 0;
      end
      e_de = (x < cur[0]) && (y < cur[4]);
      e_hs = in_win(x, cur[0] + cur[1], cur[2]);
      e_vs = in_win(y, cur[4] + cur[5], cur[6]);
      chk(de_o == (de_pol_i ? e_de : !e_de), "R4", "de_o", int'(de_o),
          int'(de_pol_i ? e_de : !e_de));
      chk(hsync_o == (e_hs ^ hs_inv_i), "R2", "hsync_o", int'(hsync_o), int'(e_hs ^ hs_inv_i));
      chk(vsync_o == (e_vs ^ vs_inv_i), "R3", "vsync_o", int'(vsync_o), int'(e_vs ^ vs_inv_i));
      if (change && !chg_done && y == 1 && x == 0) begin
        rand_cfg(pend);
        drive_cfg(pend);
        chg_done = 1;
        chg_live = 1;
      end
      px = x; py = y; have = 1;
    end
  endtask

  // R11: drop run while data enable is active.
  task automatic drop_probe();
    bit hit = 0;
    for (int i = 0; i < 400 && !hit; i++) begin
      @(posedge clk); #1;
      if (de_o == de_pol_i) hit = 1;
    end
    chk(hit, "R11", "data enable active before stop", int'(hit), 1);
    chk(ready_o == 1, "R11", "ready before stop", int'(ready_o), 1);
    run_i = 1'b0;
    #0.5;
    chk(ready_o == 0, "R11", "ready same cycle", int'(ready_o), 0);
    chk(panel_pwr_o == 0, "R11", "power same cycle", int'(panel_pwr_o), 0);
    @(posedge clk); #1;
    chk(de_o == !de_pol_i, "R11", "de_o inactive", int'(de_o), int'(!de_pol_i));
    @(negedge clk); #1;
    chk(hsync_o == hs_inv_i, "R11", "hsync_o inactive", int'(hsync_o), int'(hs_inv_i));
    chk(vsync_o == vs_inv_i, "R11", "vsync_o inactive", int'(vsync_o), int'(vs_inv_i));
  endtask

  initial begin
    int d[8];
    void'($urandom(32'd4242));
    rst_n = 0; run_i = 0; passive_i = 0; edge_sel_i = 0; edge_fall_i = 0;
    de_pol_i = 1; pclk_inv_i = 0; hs_inv_i = 1; vs_inv_i = 0;
    pup_ms_i = 1; pon_ms_i = 1;
    d[0] = 4; d[1] = 1; d[2] = 1; d[3] = 1; d[4] = 2; d[5] = 1; d[6] = 1; d[7] = 1;
    drive_cfg(d);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1;
    repeat (2) @(posedge clk);
    #1;
    chk(panel_pwr_o == 0, "R1", "panel_pwr_o after reset", int'(panel_pwr_o), 0);
    chk(ready_o == 0, "R1", "ready_o after reset", int'(ready_o), 0);
    chk(cfg_err_o == 0, "R1", "cfg_err_o after reset", int'(cfg_err_o), 0);
    chk(de_o == 0, "R1", "de_o inactive after reset", int'(de_o), 0);
    chk(hsync_o == 1, "R1", "hsync_o inactive (active low) after reset", int'(hsync_o), 1);
    chk(vsync_o == 0, "R1", "vsync_o inactive after reset", int'(vsync_o), 0);

    pwr_probe(0, 0);
    pwr_probe(1, 2);
    pwr_probe(3, 0);
    pwr_probe(0, 3);
    for (int k = 0; k < 4; k++) pwr_probe($urandom_range(0, 3), $urandom_range(0, 3));

    edge_probe(0, 0, 0, 1, "R6");
    edge_probe(1, 0, 0, 0, "R6");
    edge_probe(1, 1, 0, 1, "R6");
    edge_probe(1, 0, 1, 1, "R7");
    edge_probe(0, 1, 1, 1, "R7");

    for (int k = 0; k < 16; k++) raster(320, 0);
    for (int k = 0; k < 16; k++) raster(480, 1);
    for (int k = 0; k < 4; k++) begin
      raster(40, 0);
      drop_probe();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule